// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block supervises a processor by counting rising edges of a slow tick input that comes from a time base of its own, not from the processor clock. If software does not service it in time, the block drives a reset pulse to the processor. Because the tick is separate from the processor clock, gating that clock to save power does not freeze the count.

Software services the timer only by writing an exact pair of key bytes through the write strobe and data bus, one right after the other. The first key is 0xAA and the second is 0x55. A single write never services the timer. A stray write leaves the sequence idle. A wrong byte in the second position forces an immediate reset. A separate enable strobe turns the watchdog on. Software cannot turn it off again; only the block reset `rst_n` does that.

Top module: `kwdt_top`

## Requirements
- R1: After `rst_n`, `wdt_rst_o` is low and the watchdog is disabled. While it is disabled, no number of tick edges and no key write asserts `wdt_rst_o`.
- R2: A cycle with `en_wr` high and `wr_data[0]`=1 enables the watchdog. A later `en_wr` with `wr_data[0]`=0 has no effect, so timeouts still occur.
- R3: Once enabled, the 256th rising tick edge taken without a service asserts `wdt_rst_o`. After 255 edges it is still low.
- R4: `tick_in` is synchronised into `clk` and only its rising edges advance the count. Holding the tick high for many clock cycles counts as one edge.
- R5: A write of 0xAA followed directly by a write of 0x55, both with `wr_stb` high, restarts the count from zero.
- R6: Writes that do not form that pair do not restart the count and do not assert reset. This covers a lone 0xAA, a first write other than 0xAA, and 0x55 without a preceding 0xAA. A first write other than 0xAA leaves the sequence idle.
- R7: When enabled, a write following 0xAA with any value other than 0x55 asserts `wdt_rst_o` at the next clock edge.
- R8: `wdt_rst_o` stays high for exactly 16 rising tick edges. The count then restarts from zero, so a further 256 edges are needed for the next timeout.
- R9: When a valid second key arrives in the same clock cycle that a tick edge is taken, the service wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| wr_stb | input | 1 | Key register write strobe |
| wr_data | input | 8 | Write data (key byte; bit 0 is the enable request) |
| en_wr | input | 1 | Enable register write strobe |
| tick_in | input | 1 | Independent time-base tick, asynchronous to clk |
| wdt_rst_o | output | 1 | Reset request to the processor, active high |

## Verification
The count update and the sequence checker meet in one cycle when the second key is written in the same clock cycle that the synchronised tick edge is consumed. The bench provokes this by placing the 0x55 strobe exactly two clock cycles after it raises `tick_in`, on the 256th edge after enable, so the count would expire at that edge if the service lost. It judges the outcome by checking that `wdt_rst_o` stays low. It then checks that 255 more edges keep it low and that one more edge raises it. This shows the colliding tick was dropped rather than counted after the clear.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_e;

    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_PULSE = 1'b1
    } phase_e;

endpackage

// File: rtl/kwdt_tick_sync.sv
module kwdt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], tick_in};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_rise = s_q.sh[STAGES-1] & ~s_q.prev;

    // R4: one rising edge of the tick yields a single-cycle event
    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise);

endmodule

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq
    import kwdt_pkg::*;
#(
    parameter logic [7:0] KEY_A = 8'hAA,
    parameter logic [7:0] KEY_B = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic       svc_o,
    output logic       bad_o
);
    typedef struct packed {
        seq_e st;
    } key_t;

    key_t k_d, k_q;

    always_comb begin
        k_d   = k_q;
        svc_o = 1'b0;
        bad_o = 1'b0;
        if (wr_stb) begin
            if (k_q.st == SEQ_IDLE) begin
                k_d.st = (wr_data == KEY_A) ? SEQ_ARMED : SEQ_IDLE;
            end else begin
                k_d.st = SEQ_IDLE;
                if (wr_data == KEY_B) svc_o = 1'b1;
                else                  bad_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '{st: SEQ_IDLE};
        else        k_q <= k_d;
    end

    // R6: a first write that is not the first key leaves the sequence idle
    assert_stray_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && k_q.st == SEQ_IDLE && wr_data != KEY_A) |=> (k_q.st == SEQ_IDLE));

    // R5: a service is only ever reported on a write strobe
    assert_service_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_o |-> wr_stb);

    // R7: the sequence returns to idle after any second write
    assert_second_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_o || bad_o) |=> (k_q.st == SEQ_IDLE));

endmodule

// File: rtl/kwdt_timer.sv
module kwdt_timer
    import kwdt_pkg::*;
#(
    parameter int TIMEOUT = 256,
    parameter int PULSE   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic tick_rise,
    input  logic svc,
    input  logic bad,
    output logic rst_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam int PW = $clog2(PULSE + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
    localparam logic [PW-1:0] PLS_LAST = PW'(PULSE - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [PW-1:0] pcnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (enabled) begin
            if (t_q.ph == PH_RUN) begin
                if (bad) begin
                    t_d.ph   = PH_PULSE;
                    t_d.cnt  = '0;
                    t_d.pcnt = '0;
                end else if (svc) begin
                    t_d.cnt = '0;
                end else if (tick_rise) begin
                    if (t_q.cnt == CNT_LAST) begin
                        t_d.ph   = PH_PULSE;
                        t_d.cnt  = '0;
                        t_d.pcnt = '0;
                    end else begin
                        t_d.cnt = t_q.cnt + 1'b1;
                    end
                end
            end else if (tick_rise) begin
                if (t_q.pcnt == PLS_LAST) begin
                    t_d.ph  = PH_RUN;
                    t_d.cnt = '0;
                end else begin
                    t_d.pcnt = t_q.pcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{ph: PH_RUN, cnt: '0, pcnt: '0};
        else        t_q <= t_d;
    end

    assign rst_o = (t_q.ph == PH_PULSE);

    // R3: the count never passes the timeout limit
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= CNT_LAST);

    // R5: a service while running leaves the count at zero
    assert_service_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && t_q.ph == PH_RUN && svc) |=> (t_q.cnt == '0 && !rst_o));

    // R7: a wrong second key raises reset at the next edge
    assert_bad_key_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && t_q.ph == PH_RUN && bad) |=> rst_o);

    // R8: the pulse only ends on a tick edge
    assert_pulse_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_o && !tick_rise) |=> rst_o);

    // R1: no reset while disabled
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> !rst_o);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int         TIMEOUT     = 256,
    parameter int         PULSE       = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] KEY_A       = 8'hAA,
    parameter logic [7:0] KEY_B       = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       en_wr,
    input  logic       tick_in,
    output logic       wdt_rst_o
);
    typedef struct packed {
        logic en;
    } top_t;

    top_t c_d, c_q;
    logic tick_rise;
    logic svc;
    logic bad;

    always_comb begin
        c_d    = c_q;
        c_d.en = c_q.en | (en_wr & wr_data[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    kwdt_tick_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .tick_rise (tick_rise)
    );

    kwdt_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .svc_o   (svc),
        .bad_o   (bad)
    );

    kwdt_timer #(.TIMEOUT(TIMEOUT), .PULSE(PULSE)) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enabled   (c_q.en),
        .tick_rise (tick_rise),
        .svc       (svc),
        .bad       (bad),
        .rst_o     (wdt_rst_o)
    );

    // R2: once enabled, only the block reset turns the watchdog off
    assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.en |=> c_q.en);

endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       en_wr = 1'b0;
    logic       tick_in = 1'b0;
    logic       wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kwdt_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .en_wr     (en_wr),
        .tick_in   (tick_in),
        .wdt_rst_o (wdt_rst_o)
    );

    // vector: {two writes, first byte, second byte, outcome}
    // outcome 0 = serviced, 1 = not serviced, 2 = immediate reset
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 8'hAA, 8'h55, 2'd0},
        {1'b1, 8'h55, 8'hAA, 2'd1},
        {1'b0, 8'hAA, 8'h00, 2'd1},
        {1'b1, 8'hAA, 8'h00, 2'd2},
        {1'b1, 8'h00, 8'h55, 2'd1},
        {1'b1, 8'hAA, 8'hAA, 2'd2},
        {1'b1, 8'h55, 8'h55, 2'd1},
        {1'b1, 8'hAA, 8'h56, 2'd2}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wdt_rst_o actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        wr_stb  = 1'b0;
        en_wr   = 1'b0;
        tick_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic enable(input logic bit0);
        @(negedge clk);
        en_wr   = 1'b1;
        wr_data = {7'd0, bit0};
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_in = 1'b1;
            repeat (3) @(negedge clk);
            tick_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state and disabled behaviour
        do_reset();
        check("R1 reset state", wdt_rst_o, 1'b0);
        ticks(300);
        check("R1 no timeout while disabled", wdt_rst_o, 1'b0);
        wr(8'hAA);
        wr(8'h00);
        check("R1 bad key ignored while disabled", wdt_rst_o, 1'b0);

        // R2: enable with bit0=0 does nothing; enable is sticky
        enable(1'b0);
        ticks(260);
        check("R2 zero bit does not enable", wdt_rst_o, 1'b0);
        enable(1'b1);
        enable(1'b0);
        // R3/R4: 255 edges, one of them held high a long time
        @(negedge clk);
        tick_in = 1'b1;
        repeat (40) @(negedge clk);
        tick_in = 1'b0;
        repeat (3) @(negedge clk);
        ticks(254);
        check("R4 long high level counted once / R3 255 edges", wdt_rst_o, 1'b0);
        ticks(1);
        check("R3 timeout at 256 edges / R2 disable ignored", wdt_rst_o, 1'b1);

        // R8: pulse length and restart from zero
        ticks(15);
        check("R8 pulse still high after 15 edges", wdt_rst_o, 1'b1);
        ticks(1);
        check("R8 pulse ends after 16 edges", wdt_rst_o, 1'b0);
        ticks(255);
        check("R8 count restarted from zero", wdt_rst_o, 1'b0);
        ticks(1);
        check("R8 next timeout after 256 edges", wdt_rst_o, 1'b1);

        // R5/R6/R7: vector table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            enable(1'b1);
            ticks(200);
            wr(VEC[v][17:10]);
            if (VEC[v][18]) wr(VEC[v][9:2]);
            check($sformatf("R7 vector %0d immediate reset", v), wdt_rst_o,
                  VEC[v][1:0] == 2'd2);
            if (VEC[v][1:0] != 2'd2) begin
                ticks(60);
                check($sformatf("R5/R6 vector %0d service outcome", v), wdt_rst_o,
                      VEC[v][1:0] == 2'd1);
            end
        end

        // R9: second key collides with the expiring tick edge
        do_reset();
        enable(1'b1);
        ticks(255);
        wr(8'hAA);
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = 8'h55;
        @(negedge clk);
        wr_stb  = 1'b0;
        tick_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 service beats tick", wdt_rst_o, 1'b0);
        ticks(255);
        check("R9 colliding tick dropped", wdt_rst_o, 1'b0);
        ticks(1);
        check("R9 timeout after fresh 256 edges", wdt_rst_o, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule